// File: doc/BRIEF.md
# Not-Recently-Used Way Selector

This block holds the replacement state of a set-associative cache and names the way to evict when a miss needs space. Each set carries one reference bit per way. A bit at one means the way has not been used since the set was last reloaded. Using a way clears its bit. When the last bit in a set that is still one gets cleared, the whole set reloads to ones in the same clock edge, so no set ever holds all zeros.

The cache controller reports each access on the touch port as a set index and a way number. When it needs a victim, it raises a request with a set index. One cycle later the block returns the lowest-numbered way in that set whose bit is one, together with a valid strobe. The tag and data arrays, hit detection and line fill all sit outside this block.

Top module: `nru_repl_sel`

## Requirements
- R1: While rst_ni is low and after it rises, every reference bit in every set is one. The first victim for any set is therefore way 0, and vic_vld_o is low.
- R2: A touch (touch_vld_i high) clears only the bit of touch_way_i in set touch_set_i at the next rising edge. The bits of other ways and other sets do not change.
- R3: If a touch would leave its set with every bit at zero, all bits of that set are one after that same edge.
- R4: At every clock, every set has at least one bit at one.
- R5: The returned victim is the lowest-numbered way whose bit is one in the requested set.
- R6: vic_vld_o is high in the cycle after a cycle with vic_req_i high, and low in the cycle after a cycle with vic_req_i low. vic_way_o holds the way number as an unsigned binary index.
- R7: When a touch and a victim request hit the same set in the same cycle, the victim is chosen from the bits as they stood before that touch.
- R8: A victim request does not change any reference bit.
- R9: While touch_vld_i is low, touch_set_i and touch_way_i have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| touch_vld_i | input | 1 | An access to a way happens this cycle |
| touch_set_i | input | SET_W | Set index of the access |
| touch_way_i | input | WAY_W | Way number of the access |
| vic_req_i | input | 1 | Victim request this cycle |
| vic_set_i | input | SET_W | Set index for the victim request |
| vic_vld_o | output | 1 | Victim result valid, one cycle after the request |
| vic_way_o | output | WAY_W | Way number chosen for eviction |

## Verification
The bench walks one set through a full sweep of its ways. This catches a design that skips the reload, which would stall on an empty set, and one that reloads a cycle late, which would briefly return a stale or undefined way. It issues a touch and a request to the same set in the same cycle, where a design that forwards the new bits would answer with the next way instead of the touched one. It also checks that requests alone and touches with the valid strobe low leave the state alone, and that touching one set does not disturb its neighbours. A long random stream is then compared against a behavioural model on every cycle.

// File: rtl/nru_pkg.sv
package nru_pkg;
  localparam int unsigned NRU_DEF_SETS = 16;
  localparam int unsigned NRU_DEF_WAYS = 4;
endpackage

// File: rtl/nru_way_dec.sv
module nru_way_dec #(
  parameter int unsigned NUM_WAYS = 4,
  localparam int unsigned WAY_W = $clog2(NUM_WAYS)
) (
  input  logic [WAY_W-1:0]    way_i,
  output logic [NUM_WAYS-1:0] oh_o
);
  always_comb begin
    oh_o = '0;
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (way_i == WAY_W'(i)) oh_o[i] = 1'b1;
    end
  end
endmodule

// File: rtl/nru_set_row.sv
module nru_set_row #(
  parameter int unsigned NUM_WAYS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                hit_i,
  input  logic [NUM_WAYS-1:0] way_oh_i,
  output logic [NUM_WAYS-1:0] bits_o
);
  logic [NUM_WAYS-1:0] bits_q, cleared, bits_d;

  always_comb begin
    cleared = bits_q & ~way_oh_i;
    // reload in the same edge that would empty the set
    bits_d  = (cleared == '0) ? '1 : cleared;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    bits_q <= '1;
    else if (hit_i) bits_q <= bits_d;
  end

  assign bits_o = bits_q;
endmodule

// File: rtl/nru_lowest_pick.sv
module nru_lowest_pick #(
  parameter int unsigned NUM_WAYS = 4,
  localparam int unsigned WAY_W = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0] row_i,
  output logic [WAY_W-1:0]    way_o
);
  logic found;
  always_comb begin
    way_o = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (row_i[i] && !found) begin
        way_o = WAY_W'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/nru_repl_sel.sv
module nru_repl_sel #(
  parameter int unsigned NUM_SETS = nru_pkg::NRU_DEF_SETS,
  parameter int unsigned NUM_WAYS = nru_pkg::NRU_DEF_WAYS,
  localparam int unsigned SET_W = $clog2(NUM_SETS),
  localparam int unsigned WAY_W = $clog2(NUM_WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_vld_i,
  input  logic [SET_W-1:0] touch_set_i,
  input  logic [WAY_W-1:0] touch_way_i,
  input  logic             vic_req_i,
  input  logic [SET_W-1:0] vic_set_i,
  output logic             vic_vld_o,
  output logic [WAY_W-1:0] vic_way_o
);
  logic [NUM_WAYS-1:0]          touch_oh;
  logic [NUM_WAYS-1:0]          rows [NUM_SETS];
  logic [NUM_SETS*NUM_WAYS-1:0] st_flat;
  logic [NUM_WAYS-1:0]          req_row;
  logic [WAY_W-1:0]             pick;

  nru_way_dec #(.NUM_WAYS(NUM_WAYS)) u_dec (
    .way_i (touch_way_i),
    .oh_o  (touch_oh)
  );

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic hit;
    assign hit = touch_vld_i && (touch_set_i == SET_W'(s));
    nru_set_row #(.NUM_WAYS(NUM_WAYS)) u_row (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .hit_i    (hit),
      .way_oh_i (touch_oh),
      .bits_o   (rows[s])
    );
    assign st_flat[s*NUM_WAYS +: NUM_WAYS] = rows[s];
  end

  assign req_row = rows[vic_set_i];

  nru_lowest_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
    .row_i (req_row),
    .way_o (pick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vic_vld_o <= 1'b0;
      vic_way_o <= '0;
    end else begin
      vic_vld_o <= vic_req_i;
      if (vic_req_i) vic_way_o <= pick;
    end
  end
endmodule

// File: rtl/nru_repl_sel_chk.sv
module nru_repl_sel_chk #(
  parameter int unsigned NUM_SETS = 16,
  parameter int unsigned NUM_WAYS = 4,
  localparam int unsigned SET_W = $clog2(NUM_SETS),
  localparam int unsigned WAY_W = $clog2(NUM_WAYS)
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         touch_vld_i,
  input logic [SET_W-1:0]             touch_set_i,
  input logic [WAY_W-1:0]             touch_way_i,
  input logic                         vic_req_i,
  input logic [SET_W-1:0]             vic_set_i,
  input logic                         vic_vld_o,
  input logic [WAY_W-1:0]             vic_way_o,
  input logic [NUM_SETS*NUM_WAYS-1:0] st_flat
);
  logic [NUM_WAYS-1:0] req_row, req_row_q, low_mask, t_row, t_row_q, cur_t_row;
  logic                t_vld_q;
  logic [SET_W-1:0]    t_set_q;
  logic [WAY_W-1:0]    t_way_q;

  assign req_row   = st_flat[int'(vic_set_i)*NUM_WAYS +: NUM_WAYS];
  assign t_row     = st_flat[int'(touch_set_i)*NUM_WAYS +: NUM_WAYS];
  assign cur_t_row = st_flat[int'(t_set_q)*NUM_WAYS +: NUM_WAYS];
  assign low_mask  = (NUM_WAYS'(1) << vic_way_o) - NUM_WAYS'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_row_q <= '1;
      t_row_q   <= '1;
      t_vld_q   <= 1'b0;
      t_set_q   <= '0;
      t_way_q   <= '0;
    end else begin
      req_row_q <= req_row;
      t_row_q   <= t_row;
      t_vld_q   <= touch_vld_i;
      t_set_q   <= touch_set_i;
      t_way_q   <= touch_way_i;
    end
  end

  a_r6_vld_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vic_req_i |=> vic_vld_o);
  a_r6_vld_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vic_req_i |=> !vic_vld_o);
  a_r5_lowest_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vic_vld_o |-> (req_row_q[vic_way_o] && ((req_row_q & low_mask) == '0)));
  a_r2_touch_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t_vld_q |-> (!cur_t_row[t_way_q] || (&cur_t_row)));
  a_r3_reload_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t_vld_q && ((t_row_q & ~(NUM_WAYS'(1) << t_way_q)) == '0)) |-> (&cur_t_row));

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_nz
    a_r4_never_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
      |st_flat[s*NUM_WAYS +: NUM_WAYS]);
  end
endmodule

bind nru_repl_sel nru_repl_sel_chk #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .touch_vld_i (touch_vld_i),
  .touch_set_i (touch_set_i),
  .touch_way_i (touch_way_i),
  .vic_req_i   (vic_req_i),
  .vic_set_i   (vic_set_i),
  .vic_vld_o   (vic_vld_o),
  .vic_way_o   (vic_way_o),
  .st_flat     (st_flat)
);

// File: tb/nru_repl_sel_tb.sv
`timescale 1ns/1ps
module nru_repl_sel_tb;
  localparam int NS = 16;
  localparam int NW = 4;
  localparam int SW = $clog2(NS);
  localparam int WW = $clog2(NW);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          touch_vld = 1'b0;
  logic [SW-1:0] touch_set = '0;
  logic [WW-1:0] touch_way = '0;
  logic          vic_req = 1'b0;
  logic [SW-1:0] vic_set = '0;
  logic          vic_vld;
  logic [WW-1:0] vic_way;

  int checks = 0;
  int errors = 0;
  bit cmp_en = 1'b0;

  always #2.5 clk = ~clk;

  nru_repl_sel #(.NUM_SETS(NS), .NUM_WAYS(NW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .touch_vld_i(touch_vld), .touch_set_i(touch_set), .touch_way_i(touch_way),
    .vic_req_i(vic_req), .vic_set_i(vic_set),
    .vic_vld_o(vic_vld), .vic_way_o(vic_way)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: one bit per way per set
  bit [NW-1:0] mdl [NS];
  bit          exp_vld;
  int          exp_way;

  function automatic int first_one(bit [NW-1:0] r);
    for (int i = 0; i < NW; i++) if (r[i]) return i;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NS; s++) mdl[s] = '1;
      exp_vld = 1'b0;
      exp_way = 0;
    end else begin
      exp_vld = vic_req;
      if (vic_req) exp_way = first_one(mdl[vic_set]);
      if (touch_vld) begin
        mdl[touch_set][touch_way] = 1'b0;
        if (mdl[touch_set] == '0) mdl[touch_set] = '1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      chk("R6 valid vs model", int'(vic_vld), int'(exp_vld));
      if (exp_vld) chk("R5 victim vs model", int'(vic_way), exp_way);
    end
  end

  // tasks start and end on a falling edge
  task automatic touch(int s, int w);
    touch_vld = 1'b1; touch_set = SW'(s); touch_way = WW'(w);
    @(negedge clk);
    touch_vld = 1'b0;
  endtask

  task automatic victim_is(int s, int w, string tag);
    vic_req = 1'b1; vic_set = SW'(s);
    @(negedge clk);
    vic_req = 1'b0;
    chk(tag, int'(vic_vld), 1);
    chk(tag, int'(vic_way), w);
    @(negedge clk);
    chk("R6 valid drops", int'(vic_vld), 0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid low in reset", int'(vic_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_en = 1'b1;
    chk("R1 valid low after reset", int'(vic_vld), 0);
    for (int s = 0; s < NS; s++) victim_is(s, 0, "R1 reset victim");

    // R2 / R5 on set 2
    touch(2, 0); victim_is(2, 1, "R2 clear way0");
    touch(2, 2); victim_is(2, 1, "R5 lowest one");
    touch(2, 1); victim_is(2, 3, "R5 only way3 left");
    victim_is(5, 0, "R2 other set untouched");
    touch(2, 3); victim_is(2, 0, "R3 reload after last clear");
    touch(2, 0); victim_is(2, 1, "R3 reload left all ones");
    touch(2, 0); victim_is(2, 1, "R2 repeat touch");

    // R9: payload without strobe
    touch_set = SW'(5); touch_way = '0;
    @(negedge clk);
    victim_is(5, 0, "R9 ignored without strobe");

    // R8: requests leave state
    victim_is(7, 0, "R8 request 1");
    victim_is(7, 0, "R8 request 2");
    touch(7, 0);
    victim_is(7, 1, "R8 touch after requests");

    // R7: same-cycle touch and request
    touch_vld = 1'b1; touch_set = SW'(9); touch_way = '0;
    vic_req = 1'b1; vic_set = SW'(9);
    @(negedge clk);
    touch_vld = 1'b0; vic_req = 1'b0;
    chk("R7 pre-touch state", int'(vic_way), 0);
    @(negedge clk);
    victim_is(9, 1, "R7 touch applied");

    // R1: reset mid-run
    touch(4, 0); touch(4, 1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    victim_is(4, 0, "R1 reset reloads");
    victim_is(9, 0, "R1 reset reloads other");

    // random stream against model (R2..R9)
    for (int c = 0; c < 4000; c++) begin
      touch_vld = ($urandom_range(3) != 0);
      touch_set = SW'($urandom_range(3));
      touch_way = WW'($urandom_range(NW-1));
      vic_req   = $urandom_range(1) == 1;
      vic_set   = SW'($urandom_range(3));
      @(negedge clk);
    end
    touch_vld = 1'b0; vic_req = 1'b0;
    repeat (2) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule